// File: doc/BRIEF.md
# Channel Error-Interrupt Enable Register with Byte Set/Clear Commands

This block keeps one enable bit per DMA channel, 32 by default, that gates the channel's error interrupt. Software never writes the bitmap directly. It writes small command bytes instead. One byte sets bits and its neighbour clears them. Each command can name a single channel, act on every channel at once, or be suppressed by a no-operation flag. Because of the flag, software can issue a full 32-bit store that touches only the byte it means to use.

The block sits on a simple word-addressed slave bus with byte strobes, write data and combinational read data. Both command bytes live in one 32-bit word. The set byte is in data bits 15:8 (strobe bit 1) and the clear byte is in bits 7:0 (strobe bit 0). The bitmap drives an output port and can also be read back at its own word address.

Top module: `err_en_cmd_reg`

## Requirements
- R1: After reset the enable bitmap `irq_en` is all zeros.
- R2: A write to the command word with strobe bit 1 set and a set byte (data 15:8) whose top bit is 0 and whose 7-bit value v = data[14:8] is 0..31 sets bit v of `irq_en` and leaves every other bit unchanged.
- R3: A write to the command word with strobe bit 0 set and a clear byte (data 7:0) whose top bit is 0 and whose value v = data[6:0] is 0..31 clears bit v only.
- R4: Command values 32..63 on either byte leave the bitmap unchanged.
- R5: A set byte whose value is 64..127 (data bit 14 = 1) sets all enable bits.
- R6: A clear byte whose value is 64..127 (data bit 6 = 1) clears all enable bits.
- R7: A command byte whose top bit (data 15 for set, data 7 for clear) is 1 is ignored.
- R8: A command byte whose strobe bit is 0 is ignored, whatever it holds.
- R9: When both bytes carry valid commands in one write, the set is applied first and the clear second, so the clear wins wherever the two overlap.
- R10: Reads of the command word return zero. Reads of the bitmap word return `irq_en` in bits NCH-1:0 and zeros above. Writes to the bitmap word and to any other address leave `irq_en` unchanged.
- R11: The bitmap changes on the first rising clock edge at which the write is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write request for this cycle |
| bus_be | input | 4 | Byte strobes; bit i covers data bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_en | output | NCH | Per-channel error-interrupt enable bitmap |

## Verification
The bench builds the block with its defaults: 32 channels, command word 6 and bitmap word 7. With these values every single-channel index the 5-bit field can name is a real channel, so bit 31 and the all-ones pattern can be reached. Directed writes cover each value range of both bytes, the NOP flag, masked strobes and combined set/clear words. A long run of mixed writes then compares `irq_en` and the read data against a behavioural model on every clock.

// File: rtl/err_en_cmd_reg.sv
module err_en_cmd_reg #(
  parameter int ADDR_W = 6,
  parameter int NCH = 32,
  parameter logic [ADDR_W-1:0] CMD_WORD = 6'h06,
  parameter logic [ADDR_W-1:0] MAP_WORD = 6'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq_en
);

  localparam int SET_LANE = 1;
  localparam int CLR_LANE = 0;

  initial if (NCH < 1 || NCH > 32) $error("NCH out of range");

  function automatic logic [NCH-1:0] cmd_mask(input logic live, input logic [7:0] b);
    logic [NCH-1:0] m;
    m = '0;
    if (live && !b[7]) begin
      if (b[6]) m = '1;
      else if (!b[5])
        for (int c = 0; c < NCH; c++) m[c] = (b[4:0] == 5'(c));
    end
    return m;
  endfunction

  wire cmd_wr = bus_we && (bus_addr == CMD_WORD);
  wire [7:0] set_byte = bus_wdata[8*SET_LANE +: 8];
  wire [7:0] clr_byte = bus_wdata[8*CLR_LANE +: 8];
  wire [NCH-1:0] set_m = cmd_mask(cmd_wr && bus_be[SET_LANE], set_byte);
  wire [NCH-1:0] clr_m = cmd_mask(cmd_wr && bus_be[CLR_LANE], clr_byte);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_en <= '0;
    else        irq_en <= (irq_en | set_m) & ~clr_m;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == MAP_WORD) bus_rdata[NCH-1:0] = irq_en;
  end

  wire set_live = cmd_wr && bus_be[1] && !bus_wdata[15];
  wire clr_live = cmd_wr && bus_be[0] && !bus_wdata[7];

  assert_reset_R1: assert property (@(posedge clk) $rose(rst_n) |-> irq_en == '0);

  assert_set_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_live && bus_wdata[14:13] == 2'b00 && int'(bus_wdata[12:8]) < NCH && !clr_live)
    |=> irq_en[$past(bus_wdata[12:8])]);

  assert_clr_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_live && bus_wdata[6:5] == 2'b00 && int'(bus_wdata[4:0]) < NCH)
    |=> !irq_en[$past(bus_wdata[4:0])]);

  assert_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_live && bus_wdata[14:13] == 2'b01 && !clr_live) |=> $stable(irq_en));

  assert_set_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_live && bus_wdata[14] && !clr_live) |=> &irq_en);

  assert_clr_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_live && bus_wdata[6]) |=> irq_en == '0);

  assert_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[15] && bus_wdata[7]) |=> $stable(irq_en));

  assert_strobe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_be[1:0] == 2'b00) |=> $stable(irq_en));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_live && clr_live && bus_wdata[14:8] == bus_wdata[6:0] && bus_wdata[6:5] == 2'b00
     && int'(bus_wdata[4:0]) < NCH) |=> !irq_en[$past(bus_wdata[4:0])]);

  assert_cmd_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CMD_WORD) |-> bus_rdata == 32'h0);

  assert_other_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != CMD_WORD) |=> $stable(irq_en));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(irq_en));

endmodule

// File: tb/sim_err_en_cmd_reg.sv
`timescale 1ns/1ps
module sim_err_en_cmd_reg;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [5:0] bus_addr = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_en;
  int checks = 0, fails = 0;
  logic [31:0] mdl;
  bit done = 0;

  always #2.5 clk = ~clk;

  err_en_cmd_reg u0 (.clk, .rst_n, .bus_addr, .bus_we, .bus_be, .bus_wdata, .bus_rdata, .irq_en);

  // behavioural reference
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mdl <= 0;
    else if (bus_we && bus_addr == 6) begin
      logic [31:0] n;
      int v;
      n = mdl;
      if (bus_be[1] && !bus_wdata[15]) begin
        v = int'(bus_wdata[14:8]);
        if (v >= 64) n = '1; else if (v < 32) n[v] = 1'b1;
      end
      if (bus_be[0] && !bus_wdata[7]) begin
        v = int'(bus_wdata[6:0]);
        if (v >= 64) n = '0; else if (v < 32) n[v] = 1'b0;
      end
      mdl <= n;
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R11 model", irq_en, mdl);
    chk("R10 rdata", bus_rdata, (bus_addr == 7) ? mdl : 32'h0);
  end

  task automatic wr(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic cmd(logic [7:0] s, logic [7:0] c, logic [3:0] be = 4'b0011);
    wr(6, be, {16'hA5A5, s, c});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", irq_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", irq_en, 0);

    cmd(8'h05, 8'h80);            chk("R2 set 5", irq_en, 32'h0000_0020);
    cmd(8'h1F, 8'h80);            chk("R2 set 31", irq_en, 32'h8000_0020);
    cmd(8'h80, 8'h05);            chk("R3 clear 5", irq_en, 32'h8000_0000);
    cmd(8'h25, 8'h80);            chk("R4 reserved set", irq_en, 32'h8000_0000);
    cmd(8'h80, 8'h3F);            chk("R4 reserved clear", irq_en, 32'h8000_0000);
    cmd(8'h40, 8'h80);            chk("R5 set all 0x40", irq_en, 32'hFFFF_FFFF);
    cmd(8'h80, 8'h09);            chk("R3 clear 9", irq_en, 32'hFFFF_FDFF);
    cmd(8'h7F, 8'h80);            chk("R5 set all 0x7F", irq_en, 32'hFFFF_FFFF);
    cmd(8'h80, 8'h55);            chk("R6 clear all", irq_en, 0);
    cmd(8'h83, 8'h80);            chk("R7 nop set", irq_en, 0);
    cmd(8'h0C, 8'h80);
    cmd(8'h80, 8'h8C);            chk("R7 nop clear", irq_en, 32'h0000_1000);
    cmd(8'h04, 8'h0C, 4'b1101);   chk("R8 set strobe off", irq_en, 32'h0000_0000);
    cmd(8'h04, 8'h40, 4'b0010);   chk("R8 clear strobe off", irq_en, 32'h0000_0010);
    cmd(8'h03, 8'h03);            chk("R9 same bit", irq_en, 32'h0000_0010);
    cmd(8'h40, 8'h07);            chk("R9 all then clear 7", irq_en, 32'hFFFF_FF7F);
    cmd(8'h40, 8'h40);            chk("R9 both global", irq_en, 0);
    cmd(8'h02, 8'h80);
    wr(7, 4'hF, 32'hFFFF_FFFF);   chk("R10 map write ignored", irq_en, 32'h0000_0004);
    wr(5, 4'hF, 32'h0040_0040);   chk("R10 other write ignored", irq_en, 32'h0000_0004);
    @(negedge clk); bus_addr = 6; #1;
    chk("R10 cmd read", bus_rdata, 0);
    bus_addr = 7; #1;
    chk("R10 map read", bus_rdata, 32'h0000_0004);

    // R11: no change before the edge, change right after
    @(negedge clk);
    bus_addr = 6; bus_be = 4'b0010; bus_wdata = 32'h0000_0800; bus_we = 1;
    #1 chk("R11 before edge", irq_en, 32'h0000_0004);
    @(posedge clk); #0.5;
    chk("R11 after edge", irq_en, 32'h0000_0104);
    @(negedge clk); bus_we = 0;

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] s, c;
      logic [5:0] a;
      s = 8'($urandom); c = 8'($urandom);
      if ($urandom % 3 == 0) s[7] = 0;
      if ($urandom % 3 == 0) c[7] = 0;
      a = ($urandom % 4 == 0) ? 6'($urandom) : 6'd6;
      wr(a, 4'($urandom), {16'($urandom), s, c});
      if ($urandom % 5 == 0) begin bus_addr = 6'($urandom % 8); @(negedge clk); end
    end
    chk("R11 final", irq_en, mdl);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule